// File: doc/BRIEF.md
# Oversampled Bipolar Clock Recovery Loop

This block rebuilds the bit clock and retimed dual-rail data of a primary-rate bipolar line. It runs entirely on a reference clock at twelve times the nominal line rate. That is 18.528 MHz for 1.544 MHz operation and 24.576 MHz for 2.048 MHz operation. Its inputs are the already sliced positive and negative pulse levels. Both pulse inputs pass through a two-stage synchronizer, and the first rising edge in each bit period is timed against a phase counter.

Each bit period lasts 11, 12 or 13 reference cycles. The choice depends on whether that edge came early, on time or late against the nominal point, so the recovered clock edge follows the jitter of the line. A bit period with no pulse lasts exactly 12 cycles.

A lock monitor asserts a flag after a run of on-time pulses. It drops the flag on a loss of carrier, meaning a long run of pulse-free bit periods, and on any change of the rate select.

Top module: `rx_clock_recovery`

## Requirements
- R1: A bit period in which neither pulse input shows a rising edge lasts exactly 12 reference cycles. A bit period starts at a rising edge of `rclk`.
- R2: Let d be the number of reference cycles from the `rclk` rise to the cycle in which a pulse input first goes high. The edge is detected at phase d+2, after two synchronizer flops. An edge at phase 3 or less (d of 0 or 1) is early and makes that bit period 11 cycles.
- R3: An edge at phase 7 or more (d from 5 to 9) is late and makes that bit period 13 cycles.
- R4: An edge at phase 4, 5 or 6 (d from 2 to 4) is on time and leaves the bit period at 12 cycles.
- R5: `rpos` and `rneg` change only together with a rising edge of `rclk`. After that edge they show whether the positive or the negative input, respectively, had a rising edge in the bit period just ended.
- R6: `rclk` is high for the first 6 reference cycles of every bit period and low for the rest.
- R7: `locked` rises at the end of the bit period that completes LOCK_PULSES consecutive on-time pulses. Pulse-free periods neither count nor break the run. An early or late pulse restarts the count while unlocked and does not clear `locked` once it is set.
- R8: After LOS_ZEROS consecutive pulse-free bit periods, carrier is lost and `locked` falls. After carrier returns, it rises again only after a fresh run of LOCK_PULSES on-time pulses.
- R9: Any change of `rate_sel` (0 for 1.544 MHz, 1 for 2.048 MHz) clears `locked` on the next reference edge and restarts acquisition.
- R10: While `rst_n` is low, `rpos`, `rneg` and `locked` are 0 and `rclk` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 12x line rate |
| rst_n | input | 1 | Active-low reset |
| rate_sel | input | 1 | 0 selects 1.544 MHz, 1 selects 2.048 MHz |
| pos_in | input | 1 | Sliced positive pulse level |
| neg_in | input | 1 | Sliced negative pulse level |
| rclk | output | 1 | Recovered bit clock |
| rpos | output | 1 | Retimed positive data |
| rneg | output | 1 | Retimed negative data |
| locked | output | 1 | Loop locked, data valid |

## Verification
The bench keeps the default divide of 12, a phase window of one cycle and two synchronizer stages, so the 11, 12 and 13 cycle periods are checked exactly as built. It builds the block with LOCK_PULSES set to 4 and LOS_ZEROS set to 8 in place of 32 and 192. With those values, the rise of the lock flag, its survival across an early pulse, its drop on carrier loss and its recovery all fit in a short run. The count boundaries are still probed at N-1 and N.

// File: rtl/rx_cdr_pkg.sv
package rx_cdr_pkg;

    typedef enum logic [1:0] {
        PH_NONE   = 2'd0,
        PH_EARLY  = 2'd1,
        PH_ONTIME = 2'd2,
        PH_LATE   = 2'd3
    } phase_cls_e;

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
endmodule

// File: rtl/rx_phase_det.sv
module rx_phase_det
    import rx_cdr_pkg::*;
#(
    parameter int PW       = 4,
    parameter int EDGE_NOM = 5,
    parameter int EDGE_WIN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_any,
    input  logic [PW-1:0] ph,
    input  logic          period_end,
    output phase_cls_e    cls
);
    localparam logic [PW-1:0] EARLY_BELOW = PW'(EDGE_NOM - EDGE_WIN);
    localparam logic [PW-1:0] LATE_ABOVE  = PW'(EDGE_NOM + EDGE_WIN);

    typedef struct packed {
        logic          seen;
        logic [PW-1:0] pos;
    } state_t;

    state_t        st_d, st_q;
    logic          eff_seen;
    logic [PW-1:0] eff_pos;

    always_comb begin
        eff_seen = st_q.seen | edge_any;
        eff_pos  = st_q.seen ? st_q.pos : ph;
        if (!eff_seen)                cls = PH_NONE;
        else if (eff_pos < EARLY_BELOW) cls = PH_EARLY;
        else if (eff_pos > LATE_ABOVE)  cls = PH_LATE;
        else                          cls = PH_ONTIME;

        st_d = st_q;
        if (period_end) begin
            st_d.seen = 1'b0;
            st_d.pos  = '0;
        end else if (edge_any && !st_q.seen) begin
            st_d.seen = 1'b1;
            st_d.pos  = ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rx_divider.sv
module rx_divider
    import rx_cdr_pkg::*;
#(
    parameter int PW      = 4,
    parameter int DIV_NOM = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_cls_e    cls,
    output logic [PW-1:0] ph,
    output logic          period_end,
    output logic          rclk
);
    localparam logic [PW-1:0] LAST_NOM = PW'(DIV_NOM - 1);
    localparam logic [PW-1:0] HIGH_LEN = PW'(DIV_NOM / 2);

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          rclk;
    } state_t;

    state_t        st_d, st_q;
    logic [PW-1:0] last;

    always_comb begin
        case (cls)
            PH_EARLY: last = LAST_NOM - PW'(1);
            PH_LATE:  last = LAST_NOM + PW'(1);
            default:  last = LAST_NOM;
        endcase
        period_end = (st_q.ph >= last);

        st_d      = st_q;
        st_d.ph   = period_end ? '0 : st_q.ph + PW'(1);
        st_d.rclk = (st_d.ph < HIGH_LEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= '0;
            st_q.rclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph   = st_q.ph;
    assign rclk = st_q.rclk;
endmodule

// File: rtl/rx_lock_mon.sv
module rx_lock_mon
    import rx_cdr_pkg::*;
#(
    parameter int LOCK_PULSES = 32,
    parameter int LOS_ZEROS   = 192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       period_end,
    input  phase_cls_e cls,
    input  logic       rate_sel,
    output logic       locked,
    output logic       carrier_lost
);
    localparam int LW = $clog2(LOCK_PULSES + 1);
    localparam int ZW = $clog2(LOS_ZEROS + 1);
    localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_PULSES - 1);
    localparam logic [ZW-1:0] ZERO_LAST = ZW'(LOS_ZEROS - 1);

    typedef struct packed {
        logic [LW-1:0] run;
        logic [ZW-1:0] zeros;
        logic          locked;
        logic          lost;
        logic          rate;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rate = rate_sel;
        if (rate_sel != st_q.rate) begin
            st_d.run    = '0;
            st_d.locked = 1'b0;
        end else if (period_end) begin
            if (cls == PH_NONE) begin
                if (st_q.zeros >= ZERO_LAST) begin
                    st_d.lost   = 1'b1;
                    st_d.locked = 1'b0;
                    st_d.run    = '0;
                end else begin
                    st_d.zeros = st_q.zeros + ZW'(1);
                end
            end else begin
                st_d.zeros = '0;
                st_d.lost  = 1'b0;
                if (cls == PH_ONTIME) begin
                    if (st_q.run >= LOCK_LAST) st_d.locked = 1'b1;
                    else                       st_d.run = st_q.run + LW'(1);
                end else if (!st_q.locked) begin
                    st_d.run = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rate <= rate_sel;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked       = st_q.locked;
    assign carrier_lost = st_q.lost;
endmodule

// File: rtl/rx_clock_recovery.sv
module rx_clock_recovery
    import rx_cdr_pkg::*;
#(
    parameter int DIV_NOM     = 12,
    parameter int EDGE_NOM    = 5,
    parameter int EDGE_WIN    = 1,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_PULSES = 32,
    parameter int LOS_ZEROS   = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic pos_in,
    input  logic neg_in,
    output logic rclk,
    output logic rpos,
    output logic rneg,
    output logic locked
);
    localparam int PW    = $clog2(DIV_NOM + 2);
    localparam int LANES = 2;

    typedef struct packed {
        logic [LANES-1:0] seen;
        logic [LANES-1:0] data;
    } state_t;

    state_t           st_d, st_q;
    logic [LANES-1:0] lane_in;
    logic [LANES-1:0] lane_rise;
    logic [PW-1:0]    ph_w;
    logic             end_w;
    logic             lost_w;
    phase_cls_e       cls_w;

    assign lane_in = {neg_in, pos_in};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (lane_in[g]),
            .rise (lane_rise[g])
        );
    end

    rx_phase_det #(.PW(PW), .EDGE_NOM(EDGE_NOM), .EDGE_WIN(EDGE_WIN)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_any  (|lane_rise),
        .ph        (ph_w),
        .period_end(end_w),
        .cls       (cls_w)
    );

    rx_divider #(.PW(PW), .DIV_NOM(DIV_NOM)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls_w),
        .ph        (ph_w),
        .period_end(end_w),
        .rclk      (rclk)
    );

    rx_lock_mon #(.LOCK_PULSES(LOCK_PULSES), .LOS_ZEROS(LOS_ZEROS)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_end  (end_w),
        .cls         (cls_w),
        .rate_sel    (rate_sel),
        .locked      (locked),
        .carrier_lost(lost_w)
    );

    always_comb begin
        st_d = st_q;
        if (end_w) begin
            st_d.data = st_q.seen | lane_rise;
            st_d.seen = '0;
        end else begin
            st_d.seen = st_q.seen | lane_rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rpos = st_q.data[0];
    assign rneg = st_q.data[1];
endmodule

// File: rtl/rx_clock_recovery_chk.sv
module rx_clock_recovery_chk #(
    parameter int DIV_NOM = 12
) (
    input logic clk,
    input logic rst_n,
    input logic rate_sel,
    input logic rclk,
    input logic rpos,
    input logic rneg,
    input logic locked,
    input logic carrier_lost
);
    localparam int CW = $clog2(DIV_NOM + 3);

    logic [CW-1:0] per_q;
    logic [CW-1:0] hi_q;
    logic          rclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q       <= '0;
            hi_q        <= '0;
            rclk_prev_q <= 1'b1;
        end else begin
            rclk_prev_q <= rclk;
            per_q       <= (rclk && !rclk_prev_q) ? CW'(1) : per_q + CW'(1);
            hi_q        <= rclk ? hi_q + CW'(1) : '0;
        end
    end

    // R2
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk && !rclk_prev_q) |-> (per_q >= CW'(DIV_NOM - 1) && per_q <= CW'(DIV_NOM + 1)));

    // R6
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rclk |-> (hi_q < CW'(DIV_NOM / 2)));

    // R5
    rpos_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rpos) |-> $rose(rclk));

    // R5
    rneg_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rneg) |-> $rose(rclk));

    // R8
    lost_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_lost |-> !locked);

    // R9
    rate_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_sel) |=> !locked);
endmodule

bind rx_clock_recovery rx_clock_recovery_chk #(.DIV_NOM(DIV_NOM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .rclk        (rclk),
    .rpos        (rpos),
    .rneg        (rneg),
    .locked      (locked),
    .carrier_lost(lost_w)
);

// File: tb/rx_clock_recovery_bench.sv
module rx_clock_recovery_bench;
    localparam int NVEC = 11;

    // packing: {d[3:0], lane[1:0] (0 none, 1 pos, 2 neg), expected length[3:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {4'd0, 2'd0, 4'd12},
        {4'd0, 2'd1, 4'd11},
        {4'd1, 2'd1, 4'd11},
        {4'd2, 2'd2, 4'd12},
        {4'd3, 2'd1, 4'd12},
        {4'd4, 2'd2, 4'd12},
        {4'd5, 2'd1, 4'd13},
        {4'd7, 2'd2, 4'd13},
        {4'd9, 2'd1, 4'd13},
        {4'd0, 2'd2, 4'd11},
        {4'd0, 2'd0, 4'd12}
    };

    logic clk = 1'b0;
    logic rst_n, rate_sel, pos_in, neg_in;
    logic rclk, rpos, rneg, locked;
    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    rx_clock_recovery #(.LOCK_PULSES(4), .LOS_ZEROS(8)) u_rx_clock_recovery (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .pos_in(pos_in),
        .neg_in(neg_in), .rclk(rclk), .rpos(rpos), .rneg(rneg), .locked(locked)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic p;
        logic found;
        p = rclk;
        found = 1'b0;
        while (!found) begin
            @(negedge clk);
            if (rclk && !p) found = 1'b1;
            p = rclk;
        end
    endtask

    task automatic drive(input int lane);
        if (lane == 1) pos_in = 1'b1;
        else if (lane == 2) neg_in = 1'b1;
    endtask

    // called at the negedge right after an rclk rise; returns at the next one
    task automatic run_bit(input int d, input int lane, output int len, output int hi);
        int   i;
        logic p;
        i   = 0;
        len = 0;
        hi  = rclk ? 1 : 0;
        p   = rclk;
        if (d == 0) drive(lane);
        while (len == 0 && i < 40) begin
            @(negedge clk);
            i++;
            if (i == d) drive(lane);
            if (i == d + 3) begin pos_in = 1'b0; neg_in = 1'b0; end
            if (rclk && !p) len = i;
            else if (rclk) hi++;
            p = rclk;
        end
        pos_in = 1'b0;
        neg_in = 1'b0;
    endtask

    task automatic run_n(input int n, input int d, input int lane);
        int len, hi;
        for (int k = 0; k < n; k++) run_bit(d, lane, len, hi);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            finish_run();
        end
    end

    initial begin
        int len, hi;
        rst_n = 1'b0; rate_sel = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(rpos, 0, "R10 rpos");
        check(rneg, 0, "R10 rneg");
        check(locked, 0, "R10 locked");
        check(rclk, 1, "R10 rclk");
        rst_n = 1'b1;
        wait_rise();

        // R1 R2 R3 R4 R5 R6 vector table
        for (int v = 0; v < NVEC; v++) begin
            run_bit(int'(VEC[v][9:6]), int'(VEC[v][5:4]), len, hi);
            check(len, int'(VEC[v][3:0]), $sformatf("R1/R2/R3/R4 period v%0d", v));
            check(hi, 6, $sformatf("R6 high time v%0d", v));
            check(rpos, (VEC[v][5:4] == 2'd1) ? 1 : 0, $sformatf("R5 rpos v%0d", v));
            check(rneg, (VEC[v][5:4] == 2'd2) ? 1 : 0, $sformatf("R5 rneg v%0d", v));
        end

        // R9 restart acquisition
        rate_sel = ~rate_sel;
        @(negedge clk);
        check(locked, 0, "R9 after rate change");
        wait_rise();

        // R7 run of on-time pulses, broken by an early one
        run_n(3, 3, 1);
        check(locked, 0, "R7 three on-time");
        run_n(1, 0, 2);
        check(locked, 0, "R7 early restarts");
        run_n(3, 3, 2);
        check(locked, 0, "R7 three after restart");
        run_n(1, 3, 1);
        check(locked, 1, "R7 fourth on-time");
        run_n(1, 0, 1);
        check(locked, 1, "R7 early while locked");
        run_n(1, 8, 2);
        check(locked, 1, "R7 late while locked");

        // R8 carrier loss boundary and relock
        run_n(7, 0, 0);
        check(locked, 1, "R8 seven empty");
        run_n(1, 0, 0);
        check(locked, 0, "R8 eighth empty");
        run_n(3, 3, 1);
        check(locked, 0, "R8 three after return");
        run_n(1, 2, 2);
        check(locked, 1, "R8 relocked");

        // R9 change while locked
        rate_sel = ~rate_sel;
        @(negedge clk);
        check(locked, 0, "R9 change while locked");

        done = 1'b1;
        finish_run();
    end
endmodule